// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer

This block decides which operating mode a CAN protocol controller is in: switched off, configuration (freeze), bus synchronisation, running, or sleep with clocks stopped. Software writes a small control word of five fields: module off, hold request, stop enable, clock-source select, and software reset. The block answers with the current mode, read-back of the control fields, and the flags that drive the rest of the controller. These flags are a configuration acknowledge, an offline flag, a sleep acknowledge, the enable for the protocol engines, and the transmit pin.

Turning the module on never starts bus traffic directly. The module first parks in configuration mode with the hold and stop-enable fields set. It leaves that mode only when software clears the hold field. It then waits for eleven consecutive recessive bits on the receive line before the engines are enabled.

A software reset runs as a request/acknowledge handshake into the protocol clock domain, with two-flop synchronizers in both directions. The reset field reads back as set until the acknowledge returns. A reset request made while the module sleeps is discarded.

Top module: `canop_mode_seq`

## Requirements
- R1: After reset, mode reads 0 (off), the off, hold and stop-enable fields read 1, the clock select and software-reset fields read 0, the transmit pin is 1, the offline flag is 1, and the engine enable, configuration acknowledge and sleep acknowledge are 0.
- R2: Mode codes are off=0, configuration=1, sync=2, run=3, sleep=4. A write that clears the off field while in mode 0 moves the mode to 1 at the write edge. Hold and stop-enable then read 1 whatever values were written.
- R3: In configuration mode, the configuration acknowledge and offline flags are 1, the engine enable is 0, and the transmit pin is 1 whatever the engine's transmit value.
- R4: The clock-select field takes a written value only when the write happens in mode 0. A write in any other mode leaves it unchanged.
- R5: Configuration mode is left only by a write that clears the hold field, which moves the mode to sync (2). A write that keeps hold at 1, even with stop-enable cleared, keeps mode 1.
- R6: In sync mode, each bit strobe with the receive line at 1 counts one recessive bit, and a strobe with the line at 0 restarts the count. The mode becomes run (3) one clock after the strobe that brings the count to eleven.
- R7: In run mode, the offline flag and configuration acknowledge are 0, the engine enable is 1, and the transmit pin follows the engine's transmit input.
- R8: In run mode, writing hold=1 with stop-enable=1 returns the mode to 1. Writing hold=1 with stop-enable=0 leaves it in mode 3.
- R9: A sleep request in mode 1, 2 or 3 moves the mode to sleep (4) on the next clock, with sleep acknowledge 1, engine enable 0 and transmit pin 1. When the request drops, the mode goes to 1 if hold reads 1, else to 2.
- R10: A software-reset write made in sleep mode is discarded: the reset field stays 0, and the other fields are not reset afterwards.
- R11: An accepted software-reset write makes the reset field read 1 from the next clock. The field stays 1 while the protocol-domain reset output is raised, and clears once the acknowledge has come back.
- R12: When a software reset completes on an enabled module, the mode is 1 and hold and stop-enable read 1, while the off and clock-select fields keep their values.
- R13: A write that sets the off field moves the mode to 0 at the write edge, from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-side clock |
| rst_reg_n | input | 1 | Synchronous active-low reset, register side |
| clk_can | input | 1 | Protocol-engine clock |
| rst_can_n | input | 1 | Synchronous active-low reset, protocol side |
| cfg_wr_i | input | 1 | Control word write strobe |
| wr_off_i | input | 1 | Written value of the module-off field |
| wr_hold_i | input | 1 | Written value of the hold field |
| wr_stopen_i | input | 1 | Written value of the stop-enable field |
| wr_clksel_i | input | 1 | Written value of the clock-select field |
| wr_swrst_i | input | 1 | 1 requests a software reset |
| lpm_req_i | input | 1 | Sleep (clocks stopped) request |
| bit_tick_i | input | 1 | One-cycle strobe at each bit sample point |
| can_rx_i | input | 1 | Receive line, 1 = recessive |
| eng_tx_i | input | 1 | Transmit value from the protocol engine |
| mode_o | output | 3 | Current mode code |
| rd_off_o | output | 1 | Module-off field read-back |
| rd_hold_o | output | 1 | Hold field read-back |
| rd_stopen_o | output | 1 | Stop-enable field read-back |
| rd_clksel_o | output | 1 | Clock-select field read-back |
| rd_swrst_o | output | 1 | Software reset pending |
| cfg_ack_o | output | 1 | Configuration mode acknowledge |
| offline_o | output | 1 | Not synchronised to the bus |
| sleep_ack_o | output | 1 | Sleep mode acknowledge |
| eng_en_o | output | 1 | Enable for the protocol engines |
| can_tx_o | output | 1 | Transmit pin drive |
| eng_rst_o | output | 1 | Reset to the engines, protocol clock domain |

## Verification
The mode register drives every flag from the same clock edge. A wrong mode therefore shows on mode_o, the acknowledges and the transmit pin in the first cycle after the faulty edge, and the scoreboard compares all of them as one word. A bad recessive count shows as entering run one strobe early or late, which the ten-then-eleven bit sequence exposes. A stuck or early-clearing reset handshake shows as the reset field clearing before the protocol-side reset was seen, or never clearing within the bench's poll window.

// File: rtl/canop_pkg.sv
// Shared types for the CAN operating-mode sequencer.
// Assumes: mode codes are visible on the top port and must stay fixed.
package canop_pkg;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_CFG   = 3'd1,
        MODE_SYNC  = 3'd2,
        MODE_RUN   = 3'd3,
        MODE_SLEEP = 3'd4
    } op_mode_e;

endpackage

// File: rtl/canop_sync.sv
// Multi-flop level synchronizer.
// Assumes: the input is a level held for longer than STAGES destination clocks.
module canop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/canop_swrst_hs.sv
// Software-reset request/acknowledge handshake across the two clock domains.
// The register side holds a request level until the synchronized acknowledge
// returns; the protocol side resets its engines while it sees the request.
// Assumes: start_i is only raised when busy_o is low.
module canop_swrst_hs #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_reg,
    input  logic rst_reg_n,
    input  logic clk_can,
    input  logic rst_can_n,
    input  logic start_i,
    output logic pending_o,
    output logic busy_o,
    output logic done_o,
    output logic eng_rst_o
);
    logic req_q;
    logic ack_q;
    logic req_s;
    logic ack_s;

    canop_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_can), .rst_n(rst_can_n), .d_i(req_q), .q_o(req_s)
    );

    canop_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_reg), .rst_n(rst_reg_n), .d_i(ack_q), .q_o(ack_s)
    );

    // Register side: raise the request, drop it once the acknowledge is back.
    always_ff @(posedge clk_reg) begin
        if (!rst_reg_n)            req_q <= 1'b0;
        else if (start_i)          req_q <= 1'b1;
        else if (req_q && ack_s)   req_q <= 1'b0;
    end

    // Protocol side: acknowledge one clock after the engines enter reset.
    always_ff @(posedge clk_can) begin
        if (!rst_can_n) ack_q <= 1'b0;
        else            ack_q <= req_s;
    end

    assign pending_o = req_q;
    assign done_o    = req_q && ack_s;
    assign busy_o    = req_q || ack_s;
    assign eng_rst_o = req_s;

    // R11
    start_idle_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
        start_i |-> !busy_o);

    // R11
    pend_hold_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
        (req_q && !ack_s) |=> req_q);
endmodule

// File: rtl/canop_idle_det.sv
// Counts consecutive recessive bits while enabled and flags when the
// required number has been seen; a dominant bit restarts the count.
// Assumes: tick_i is a single-cycle strobe at the bit sample point.
module canop_idle_det #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic rx_i,
    output logic seen_o
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_q;

    // Count recessive strobes, saturate at the limit, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)     cnt_q <= '0;
        else if (tick_i) begin
            if (!rx_i)           cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign seen_o = (cnt_q == LIMIT);

    // R6
    seen_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen_o) |-> $past(tick_i && rx_i && en_i));
endmodule

// File: rtl/canop_mode_ctrl.sv
// Operating-mode state machine and control-field storage.
// Writes take effect at the write edge; enabling always parks in
// configuration mode; a completed software reset re-parks there.
// Assumes: sr_done_i is a one-cycle pulse from the handshake block.
module canop_mode_ctrl
    import canop_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr_i,
    input  logic     wr_off_i,
    input  logic     wr_hold_i,
    input  logic     wr_stopen_i,
    input  logic     wr_clksel_i,
    input  logic     wr_swrst_i,
    input  logic     lpm_req_i,
    input  logic     idle_seen_i,
    input  logic     sr_busy_i,
    input  logic     sr_done_i,
    output op_mode_e mode_o,
    output logic     sr_start_o,
    output logic     off_o,
    output logic     hold_o,
    output logic     stopen_o,
    output logic     clksel_o
);
    op_mode_e mode_q, mode_n;
    logic off_q, hold_q, stp_q, csel_q;
    logic off_w, hold_w, stp_w;
    logic sr_req, sleep_ok, enter_cfg;

    assign off_w    = cfg_wr_i ? wr_off_i    : off_q;
    assign hold_w   = cfg_wr_i ? wr_hold_i   : hold_q;
    assign stp_w    = cfg_wr_i ? wr_stopen_i : stp_q;
    assign sr_req   = cfg_wr_i && wr_swrst_i && (mode_q != MODE_SLEEP) && !sr_busy_i;
    assign sleep_ok = lpm_req_i && !sr_busy_i && !sr_req;

    // Next-mode selection; reset completion and switch-off take priority.
    always_comb begin
        mode_n = mode_q;
        if (sr_done_i)   mode_n = off_w ? MODE_OFF : MODE_CFG;
        else if (off_w)  mode_n = MODE_OFF;
        else begin
            case (mode_q)
                MODE_OFF:   mode_n = MODE_CFG;
                MODE_CFG: begin
                    if (sleep_ok)            mode_n = MODE_SLEEP;
                    else if (!hold_w)        mode_n = MODE_SYNC;
                end
                MODE_SYNC: begin
                    if (sleep_ok)            mode_n = MODE_SLEEP;
                    else if (hold_w && stp_w) mode_n = MODE_CFG;
                    else if (idle_seen_i)    mode_n = MODE_RUN;
                end
                MODE_RUN: begin
                    if (sleep_ok)            mode_n = MODE_SLEEP;
                    else if (hold_w && stp_w) mode_n = MODE_CFG;
                end
                MODE_SLEEP: begin
                    if (!lpm_req_i)          mode_n = hold_w ? MODE_CFG : MODE_SYNC;
                end
                default:                     mode_n = MODE_OFF;
            endcase
        end
    end

    assign enter_cfg = (mode_q == MODE_OFF) && (mode_n == MODE_CFG);

    // Mode and control-field registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            off_q  <= 1'b1;
            hold_q <= 1'b1;
            stp_q  <= 1'b1;
            csel_q <= 1'b0;
        end else begin
            mode_q <= mode_n;
            off_q  <= off_w;
            if (sr_done_i || enter_cfg) begin
                hold_q <= 1'b1;
                stp_q  <= 1'b1;
            end else begin
                hold_q <= hold_w;
                stp_q  <= stp_w;
            end
            if (cfg_wr_i && mode_q == MODE_OFF) csel_q <= wr_clksel_i;
        end
    end

    assign mode_o     = mode_q;
    assign sr_start_o = sr_req;
    assign off_o      = off_q;
    assign hold_o     = hold_q;
    assign stopen_o   = stp_q;
    assign clksel_o   = csel_q;

    // R2
    enter_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CFG && $past(mode_q) == MODE_OFF) |-> (hold_q && stp_q));

    // R4
    clksel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csel_q) |-> ($past(mode_q) == MODE_OFF));

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && $past(mode_q) != MODE_RUN) |-> ($past(mode_q) == MODE_SYNC));
endmodule

// File: rtl/canop_mode_seq.sv
// Top of the CAN operating-mode sequencer: mode machine, recessive-bit
// synchronisation detector and the cross-domain software-reset handshake.
// Assumes: clk_reg and clk_can are unrelated; bit_tick_i and can_rx_i are
// already in the clk_reg domain.
module canop_mode_seq
    import canop_pkg::*;
#(
    parameter int IDLE_BITS   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_reg,
    input  logic       rst_reg_n,
    input  logic       clk_can,
    input  logic       rst_can_n,
    input  logic       cfg_wr_i,
    input  logic       wr_off_i,
    input  logic       wr_hold_i,
    input  logic       wr_stopen_i,
    input  logic       wr_clksel_i,
    input  logic       wr_swrst_i,
    input  logic       lpm_req_i,
    input  logic       bit_tick_i,
    input  logic       can_rx_i,
    input  logic       eng_tx_i,
    output logic [2:0] mode_o,
    output logic       rd_off_o,
    output logic       rd_hold_o,
    output logic       rd_stopen_o,
    output logic       rd_clksel_o,
    output logic       rd_swrst_o,
    output logic       cfg_ack_o,
    output logic       offline_o,
    output logic       sleep_ack_o,
    output logic       eng_en_o,
    output logic       can_tx_o,
    output logic       eng_rst_o
);
    op_mode_e mode_s;
    logic idle_seen, sr_busy, sr_done, sr_start;

    canop_mode_ctrl u_ctrl (
        .clk(clk_reg), .rst_n(rst_reg_n),
        .cfg_wr_i(cfg_wr_i), .wr_off_i(wr_off_i), .wr_hold_i(wr_hold_i),
        .wr_stopen_i(wr_stopen_i), .wr_clksel_i(wr_clksel_i), .wr_swrst_i(wr_swrst_i),
        .lpm_req_i(lpm_req_i), .idle_seen_i(idle_seen),
        .sr_busy_i(sr_busy), .sr_done_i(sr_done),
        .mode_o(mode_s), .sr_start_o(sr_start),
        .off_o(rd_off_o), .hold_o(rd_hold_o), .stopen_o(rd_stopen_o), .clksel_o(rd_clksel_o)
    );

    canop_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk_reg), .rst_n(rst_reg_n), .en_i(mode_s == MODE_SYNC),
        .tick_i(bit_tick_i), .rx_i(can_rx_i), .seen_o(idle_seen)
    );

    canop_swrst_hs #(.SYNC_STAGES(SYNC_STAGES)) u_swrst (
        .clk_reg(clk_reg), .rst_reg_n(rst_reg_n), .clk_can(clk_can), .rst_can_n(rst_can_n),
        .start_i(sr_start), .pending_o(rd_swrst_o), .busy_o(sr_busy),
        .done_o(sr_done), .eng_rst_o(eng_rst_o)
    );

    assign mode_o      = mode_s;
    assign cfg_ack_o   = (mode_s == MODE_CFG);
    assign offline_o   = (mode_s != MODE_RUN);
    assign sleep_ack_o = (mode_s == MODE_SLEEP);
    assign eng_en_o    = (mode_s == MODE_RUN);
    assign can_tx_o    = (mode_s == MODE_RUN) ? eng_tx_i : 1'b1;

    // R3
    tx_recessive_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
        !eng_en_o |-> can_tx_o);

    // R10
    swrst_sleep_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
        $rose(rd_swrst_o) |-> ($past(mode_s) != MODE_SLEEP));
endmodule

// File: tb/canop_mode_seq_bench.sv
// Scoreboard bench: driver tasks push expected status words, a monitor
// pops and compares them at the falling clock edge.
module canop_mode_seq_bench;
    logic clk_reg = 1'b0, clk_can = 1'b0;
    logic rst_reg_n = 1'b0, rst_can_n = 1'b0;
    logic cfg_wr = 1'b0, w_off = 1'b0, w_hold = 1'b0, w_stp = 1'b0, w_csel = 1'b0, w_sr = 1'b0;
    logic lpm_req = 1'b0, bit_tick = 1'b0, can_rx = 1'b1, eng_tx = 1'b0;
    logic [2:0] mode;
    logic rd_off, rd_hold, rd_stp, rd_csel, rd_sr, cfg_ack, offline, sleep_ack, eng_en, can_tx, eng_rst;

    int checks = 0;
    int fails  = 0;
    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #5 clk_reg = ~clk_reg;
    always #8 clk_can = ~clk_can;

    canop_mode_seq u_canop_mode_seq (
        .clk_reg(clk_reg), .rst_reg_n(rst_reg_n), .clk_can(clk_can), .rst_can_n(rst_can_n),
        .cfg_wr_i(cfg_wr), .wr_off_i(w_off), .wr_hold_i(w_hold), .wr_stopen_i(w_stp),
        .wr_clksel_i(w_csel), .wr_swrst_i(w_sr), .lpm_req_i(lpm_req),
        .bit_tick_i(bit_tick), .can_rx_i(can_rx), .eng_tx_i(eng_tx),
        .mode_o(mode), .rd_off_o(rd_off), .rd_hold_o(rd_hold), .rd_stopen_o(rd_stp),
        .rd_clksel_o(rd_csel), .rd_swrst_o(rd_sr), .cfg_ack_o(cfg_ack), .offline_o(offline),
        .sleep_ack_o(sleep_ack), .eng_en_o(eng_en), .can_tx_o(can_tx), .eng_rst_o(eng_rst)
    );

    // Expected status word from the requirement rules for each mode.
    function automatic logic [12:0] mkv(input logic [2:0] m, input logic off, hold, stp, csel, sr);
        logic run = (m == 3'd3);
        return {m, (m == 3'd1), !run, (run ? eng_tx : 1'b1), run, (m == 3'd4),
                off, hold, stp, csel, sr};
    endfunction

    // Monitor: compare the next expected word with the ports.
    always @(negedge clk_reg) begin
        if (exp_q.size() != 0) begin
            logic [12:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {mode, cfg_ack, offline, can_tx, eng_en, sleep_ack,
                 rd_off, rd_hold, rd_stp, rd_csel, rd_sr};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual=%b expected=%b", t, a, e);
            end
        end
    end

    task automatic expect_vec(input string tag, input logic [2:0] m,
                              input logic off, hold, stp, csel, sr);
        exp_q.push_back(mkv(m, off, hold, stp, csel, sr));
        tag_q.push_back(tag);
        @(negedge clk_reg); #1;
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic off, hold, stp, csel, sr);
        @(posedge clk_reg); #1;
        cfg_wr = 1'b1; w_off = off; w_hold = hold; w_stp = stp; w_csel = csel; w_sr = sr;
        @(posedge clk_reg); #1;
        cfg_wr = 1'b0; w_sr = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        @(posedge clk_reg); #1;
        can_rx = v; bit_tick = 1'b1;
        @(posedge clk_reg); #1;
        bit_tick = 1'b0; can_rx = 1'b1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk_reg);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic saw_rst;
        logic cleared;
        repeat (5) @(posedge clk_reg);
        #1; rst_reg_n = 1'b1; rst_can_n = 1'b1;

        expect_vec("R1 reset state", 3'd0, 1, 1, 1, 0, 0);
        wr(1, 1, 1, 1, 0);
        expect_vec("R4 clock select written while off", 3'd0, 1, 1, 1, 1, 0);
        wr(0, 0, 0, 1, 0);
        expect_vec("R2 enable parks in configuration", 3'd1, 0, 1, 1, 1, 0);
        eng_tx = 1'b1;
        expect_vec("R3 configuration outputs", 3'd1, 0, 1, 1, 1, 0);
        eng_tx = 1'b0;
        expect_vec("R3 transmit pin recessive", 3'd1, 0, 1, 1, 1, 0);
        wr(0, 1, 1, 0, 0);
        expect_vec("R4 clock select ignored outside off", 3'd1, 0, 1, 1, 1, 0);
        wr(0, 1, 0, 1, 0);
        expect_vec("R5 hold kept stays in configuration", 3'd1, 0, 1, 0, 1, 0);
        wr(0, 0, 1, 1, 0);
        expect_vec("R5 hold cleared enters sync", 3'd2, 0, 0, 1, 1, 0);

        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        @(posedge clk_reg); #1;
        expect_vec("R6 ten recessive after dominant stays sync", 3'd2, 0, 0, 1, 1, 0);
        send_bit(1'b1);
        @(posedge clk_reg); #1;
        expect_vec("R6 eleventh recessive enters run", 3'd3, 0, 0, 1, 1, 0);
        eng_tx = 1'b1;
        expect_vec("R7 transmit follows engine high", 3'd3, 0, 0, 1, 1, 0);
        eng_tx = 1'b0;
        expect_vec("R7 transmit follows engine low", 3'd3, 0, 0, 1, 1, 0);

        wr(0, 1, 0, 1, 0);
        expect_vec("R8 hold without stop-enable stays run", 3'd3, 0, 1, 0, 1, 0);
        wr(0, 1, 1, 1, 0);
        expect_vec("R8 hold with stop-enable returns to configuration", 3'd1, 0, 1, 1, 1, 0);

        @(posedge clk_reg); #1; lpm_req = 1'b1;
        @(posedge clk_reg); #1;
        expect_vec("R9 sleep entry", 3'd4, 0, 1, 1, 1, 0);
        @(posedge clk_reg); #1; lpm_req = 1'b0;
        @(posedge clk_reg); #1;
        expect_vec("R9 sleep exit with hold to configuration", 3'd1, 0, 1, 1, 1, 0);

        @(posedge clk_reg); #1; lpm_req = 1'b1;
        @(posedge clk_reg); #1;
        wr(0, 0, 1, 1, 1);
        expect_vec("R10 software reset discarded in sleep", 3'd4, 0, 0, 1, 1, 0);
        @(posedge clk_reg); #1; lpm_req = 1'b0;
        @(posedge clk_reg); #1;
        expect_vec("R9 sleep exit without hold to sync", 3'd2, 0, 0, 1, 1, 0);
        repeat (20) @(posedge clk_reg);
        #1;
        expect_vec("R10 no late reset after sleep", 3'd2, 0, 0, 1, 1, 0);

        for (int i = 0; i < 11; i++) send_bit(1'b1);
        @(posedge clk_reg); #1;
        expect_vec("R6 resync after sleep", 3'd3, 0, 0, 1, 1, 0);

        wr(0, 0, 1, 1, 1);
        expect_vec("R11 reset field set while pending", 3'd3, 0, 0, 1, 1, 1);
        saw_rst = 1'b0;
        cleared = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk_reg);
            if (eng_rst) saw_rst = 1'b1;
            if (!rd_sr) begin
                cleared = 1'b1;
                break;
            end
        end
        #1;
        chk_bit("R11 engine reset seen while pending", saw_rst, 1'b1);
        chk_bit("R11 reset field clears on acknowledge", cleared, 1'b1);
        expect_vec("R12 state after software reset", 3'd1, 0, 1, 1, 1, 0);
        repeat (10) @(posedge clk_reg);

        wr(1, 1, 1, 0, 0);
        expect_vec("R13 switch off", 3'd0, 1, 1, 1, 1, 0);
        wr(1, 1, 1, 0, 0);
        expect_vec("R4 clock select writable again when off", 3'd0, 1, 1, 1, 0, 0);

        summary();
        $finish;
    end
endmodule